// File: doc/BRIEF.md
# Iterative Multiply Execute Sequencer

This block runs the execute stage of a multi-cycle multiply unit inside a short in-order integer pipeline. Each accepted operation carries a 3-bit class code. The class sets how many passes the operation makes through the multiplier array while it sits in execute. It also sets the cycle in which the value result may be forwarded, and whether a condition-flag result follows. While more passes remain, the block raises `stall` so that upstream issue holds the next operation. After the final pass, the operation moves through one memory-stage cycle and one writeback-stage cycle.

The execute stage is a small state machine with three states. `EX_IDLE` means execute is empty. `EX_LOOP` means a pass is running and at least one more follows. `EX_FINAL` means the last pass is running. The transitions are:

- `EX_IDLE` and `EX_FINAL` move to `EX_FINAL` on an accepted one-pass operation, or to `EX_LOOP` on an accepted multi-pass operation.
- `EX_FINAL` drops to `EX_IDLE` when nothing is accepted.
- `EX_LOOP` stays in `EX_LOOP` until the pass counter reaches the operation's pass count, then moves to `EX_FINAL`.

Because an operation can be accepted during `EX_FINAL`, operations stream back to back with no bubble. The product itself is computed behaviourally when the operation is accepted.

Three strobes report results:

- `lo_ready` marks the cycle in which the low word can be used.
- `value_ready` marks the cycle in which the whole value can be used.
- `flags_ready` marks the cycle in which the N and Z flags are valid.

`fwd_data` carries the result during either data strobe.

Top module: `mulseq_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `stall`, `ex_busy`, `mem_valid`, `wb_valid`, every strobe, `fwd_data`, `flag_n` and `flag_z` are all zero.
- R2: An operation is accepted on a rising edge where `issue_valid` is high and `stall` is low. The accepted operation occupies execute from the next cycle. `stall` is high in every execute cycle except the last pass, and `issue_valid` has no effect while `stall` is high.
- R3: Class codes set the execute pass count:
  - 0 is a halfword multiply, 1 pass.
  - 1 is a halfword multiply-accumulate, 2 passes.
  - 2 is a 32-bit multiply, 2 passes.
  - 3 is a flag-setting 32-bit multiply, 4 passes.
  - 4 is a 64-bit-result multiply, 3 passes.
  - 5 is a flag-setting 64-bit-result multiply, 5 passes.
  - Codes 6 and 7 behave exactly like code 0.
  - `ex_busy` is high for exactly that many consecutive cycles.
- R4: `mem_valid` is high for the one cycle after the last pass, and `wb_valid` is high for the cycle after that.
- R5: For classes 0, 2, 4, 6 and 7, `value_ready` pulses in the writeback cycle. For class 1 it pulses in the memory cycle.
- R6: For class 3, `value_ready` pulses in pass 4, after three passes complete. For class 5 it pulses in pass 5, after four passes complete.
- R7: `flags_ready` pulses in the memory cycle of classes 3 and 5 only. In that cycle:
  - `flag_n` is the top bit of the 32-bit result (class 3) or of the 64-bit result (class 5).
  - `flag_z` is high when that result is zero.
  - Outside `flags_ready`, both flags read zero.
- R8: For 32-bit classes, `lo_ready` pulses together with `value_ready`. For classes 4 and 5, `lo_ready` pulses exactly one cycle before `value_ready`.
- R9: `fwd_data` is valid whenever `lo_ready` or `value_ready` is high, and is zero otherwise. Its value depends on the class:
  - Classes 0, 6 and 7: the signed product of the low 16-bit halves of `op_a` and `op_b`, as 32 bits, zero-extended.
  - Class 1: that product plus `op_acc`, modulo 2^32.
  - Classes 2 and 3: the low 32 bits of the unsigned product, zero-extended.
  - Classes 4 and 5: the full 64-bit unsigned product.
- R10: Operations of any classes issued back to back overlap in the memory and writeback stages. No strobe of one operation is lost or merged with a strobe of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An operation is offered for execute |
| issue_class | input | 3 | Class code of the offered operation |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| op_acc | input | 32 | Accumulate addend (class 1) |
| stall | output | 1 | Execute cannot take a new operation next edge |
| ex_busy | output | 1 | Execute stage occupied |
| mem_valid | output | 1 | Memory stage occupied |
| wb_valid | output | 1 | Writeback stage occupied |
| lo_ready | output | 1 | Low result word forwardable this cycle |
| value_ready | output | 1 | Whole value result forwardable this cycle |
| flags_ready | output | 1 | N and Z flags valid this cycle |
| fwd_data | output | 64 | Forwarded result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The assertions assume that `issue_class` always holds a known value whenever `issue_valid` is high, and that reset is applied before the first operation. Under those assumptions every class code leads to a defined pass count and ready point, and the strobe sequencing they check cannot be reached through an undefined profile. The stimulus drives only known class codes, including the two reserved codes. While `stall` is high it holds each operation steady with `issue_valid` high. It releases reset on a falling edge, so no assertion sees an input change at a sampling edge.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

    localparam int MAX_PASSES = 5;
    localparam int PASS_W     = $clog2(MAX_PASSES + 1);

    typedef enum logic [2:0] {
        CLS_HMUL  = 3'd0,
        CLS_HMAC  = 3'd1,
        CLS_MUL   = 3'd2,
        CLS_MULF  = 3'd3,
        CLS_LMUL  = 3'd4,
        CLS_LMULF = 3'd5,
        CLS_RSV6  = 3'd6,
        CLS_RSV7  = 3'd7
    } mclass_e;

    typedef enum logic [1:0] {
        RDY_EXEC = 2'd0,
        RDY_MEM  = 2'd1,
        RDY_WB   = 2'd2
    } rdy_pt_e;

    typedef enum logic [1:0] {
        EX_IDLE  = 2'd0,
        EX_LOOP  = 2'd1,
        EX_FINAL = 2'd2
    } ex_state_e;

    function automatic logic [PASS_W-1:0] pass_count(mclass_e c);
        unique case (c)
            CLS_HMAC, CLS_MUL:                   return PASS_W'(2);
            CLS_MULF:                            return PASS_W'(4);
            CLS_LMUL:                            return PASS_W'(3);
            CLS_LMULF:                           return PASS_W'(5);
            CLS_HMUL, CLS_RSV6, CLS_RSV7:        return PASS_W'(1);
        endcase
    endfunction

    function automatic rdy_pt_e val_point(mclass_e c);
        unique case (c)
            CLS_HMAC:                            return RDY_MEM;
            CLS_MULF, CLS_LMULF:                 return RDY_EXEC;
            CLS_HMUL, CLS_MUL, CLS_LMUL,
            CLS_RSV6, CLS_RSV7:                  return RDY_WB;
        endcase
    endfunction

    function automatic logic is_wide(mclass_e c);
        return (c == CLS_LMUL) || (c == CLS_LMULF);
    endfunction

    function automatic logic sets_flags(mclass_e c);
        return (c == CLS_MULF) || (c == CLS_LMULF);
    endfunction

endpackage

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl
    import mulseq_pkg::*;
#(
    parameter int CNT_W = PASS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [CNT_W-1:0] issue_passes,
    output logic             accept,
    output logic             stall,
    output logic             ex_busy,
    output logic             ex_last,
    output logic [CNT_W-1:0] ex_pass
);

    ex_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] len_q, len_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EX_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            len_q   <= len_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        len_d   = len_q;
        accept  = issue_valid && (state_q != EX_LOOP);
        unique case (state_q)
            EX_IDLE, EX_FINAL: begin
                if (accept) begin
                    cnt_d   = CNT_W'(1);
                    len_d   = issue_passes;
                    state_d = (issue_passes == CNT_W'(1)) ? EX_FINAL : EX_LOOP;
                end else begin
                    cnt_d   = '0;
                    len_d   = '0;
                    state_d = EX_IDLE;
                end
            end
            EX_LOOP: begin
                cnt_d   = cnt_q + CNT_W'(1);
                state_d = (cnt_d == len_q) ? EX_FINAL : EX_LOOP;
            end
            default: state_d = EX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        stall   = (state_q == EX_LOOP);
        ex_busy = (state_q != EX_IDLE);
        ex_last = (state_q == EX_FINAL);
        ex_pass = cnt_q;
    end

endmodule

// File: rtl/mulseq_exu.sv
module mulseq_exu
    import mulseq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  mclass_e             cls_in,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic [DATA_W-1:0]   op_acc,
    output mclass_e             e_cls,
    output logic [2*DATA_W-1:0] e_res
);

    localparam int HW    = DATA_W / 2;
    localparam int RES_W = 2 * DATA_W;

    logic [DATA_W-1:0] ha_ext, hb_ext, hprod;
    logic [RES_W-1:0]  wa, wb, wprod, res_d;

    always_comb begin
        ha_ext = {{HW{op_a[HW-1]}}, op_a[HW-1:0]};
        hb_ext = {{HW{op_b[HW-1]}}, op_b[HW-1:0]};
        hprod  = ha_ext * hb_ext;
        wa     = {{DATA_W{1'b0}}, op_a};
        wb     = {{DATA_W{1'b0}}, op_b};
        wprod  = wa * wb;
        unique case (cls_in)
            CLS_HMAC:            res_d = {{DATA_W{1'b0}}, hprod + op_acc};
            CLS_MUL, CLS_MULF:   res_d = {{DATA_W{1'b0}}, wprod[DATA_W-1:0]};
            CLS_LMUL, CLS_LMULF: res_d = wprod;
            CLS_HMUL, CLS_RSV6,
            CLS_RSV7:            res_d = {{DATA_W{1'b0}}, hprod};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_cls <= CLS_HMUL;
            e_res <= '0;
        end else if (accept) begin
            e_cls <= cls_in;
            e_res <= res_d;
        end
    end

endmodule

// File: rtl/mulseq_tail.sv
module mulseq_tail
    import mulseq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ex_last,
    input  mclass_e             e_cls,
    input  logic [2*DATA_W-1:0] e_res,
    output logic                m_valid,
    output mclass_e             m_cls,
    output logic [2*DATA_W-1:0] m_res,
    output logic                w_valid,
    output mclass_e             w_cls,
    output logic [2*DATA_W-1:0] w_res
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_cls   <= CLS_HMUL;
            m_res   <= '0;
            w_valid <= 1'b0;
            w_cls   <= CLS_HMUL;
            w_res   <= '0;
        end else begin
            m_valid <= ex_last;
            m_cls   <= e_cls;
            m_res   <= e_res;
            w_valid <= m_valid;
            w_cls   <= m_cls;
            w_res   <= m_res;
        end
    end

endmodule

// File: rtl/mulseq_top.sv
module mulseq_top
    import mulseq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_valid,
    input  logic [2:0]          issue_class,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic [DATA_W-1:0]   op_acc,
    output logic                stall,
    output logic                ex_busy,
    output logic                mem_valid,
    output logic                wb_valid,
    output logic                lo_ready,
    output logic                value_ready,
    output logic                flags_ready,
    output logic [2*DATA_W-1:0] fwd_data,
    output logic                flag_n,
    output logic                flag_z
);

    localparam int RES_W = 2 * DATA_W;

    mclass_e           in_cls, e_cls, m_cls, w_cls;
    logic              accept, ex_last;
    logic [PASS_W-1:0] ex_pass, in_passes;
    logic [RES_W-1:0]  e_res, m_res, w_res;
    logic              e_val, e_lo, m_val, m_lo, w_val;

    assign in_cls    = mclass_e'(issue_class);
    assign in_passes = pass_count(in_cls);

    mulseq_ctrl #(.CNT_W(PASS_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_valid  (issue_valid),
        .issue_passes (in_passes),
        .accept       (accept),
        .stall        (stall),
        .ex_busy      (ex_busy),
        .ex_last      (ex_last),
        .ex_pass      (ex_pass)
    );

    mulseq_exu #(.DATA_W(DATA_W)) u_exu (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .cls_in (in_cls),
        .op_a   (op_a),
        .op_b   (op_b),
        .op_acc (op_acc),
        .e_cls  (e_cls),
        .e_res  (e_res)
    );

    mulseq_tail #(.DATA_W(DATA_W)) u_tail (
        .clk     (clk),
        .rst_n   (rst_n),
        .ex_last (ex_last),
        .e_cls   (e_cls),
        .e_res   (e_res),
        .m_valid (mem_valid),
        .m_cls   (m_cls),
        .m_res   (m_res),
        .w_valid (wb_valid),
        .w_cls   (w_cls),
        .w_res   (w_res)
    );

    // ready-point decode per stage
    always_comb begin
        e_val = ex_last && (val_point(e_cls) == RDY_EXEC);
        e_lo  = ex_busy && is_wide(e_cls) && (val_point(e_cls) == RDY_EXEC)
                && (ex_pass == pass_count(e_cls) - PASS_W'(1));
        m_val = mem_valid && (val_point(m_cls) == RDY_MEM);
        m_lo  = mem_valid && is_wide(m_cls) && (val_point(m_cls) == RDY_WB);
        w_val = wb_valid && (val_point(w_cls) == RDY_WB);

        value_ready = e_val || m_val || w_val;
        lo_ready    = e_lo || m_lo
                      || (e_val && !is_wide(e_cls))
                      || (m_val && !is_wide(m_cls))
                      || (w_val && !is_wide(w_cls));

        if (e_val || e_lo)      fwd_data = e_res;
        else if (m_val || m_lo) fwd_data = m_res;
        else if (w_val)         fwd_data = w_res;
        else                    fwd_data = '0;

        flags_ready = mem_valid && sets_flags(m_cls);
        flag_n = 1'b0;
        flag_z = 1'b0;
        if (flags_ready) begin
            flag_n = is_wide(m_cls) ? m_res[RES_W-1] : m_res[DATA_W-1];
            flag_z = is_wide(m_cls) ? (m_res == '0) : (m_res[DATA_W-1:0] == '0);
        end
    end

endmodule

// File: rtl/mulseq_chk.sv
module mulseq_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                stall,
    input logic                ex_busy,
    input logic                mem_valid,
    input logic                wb_valid,
    input logic                lo_ready,
    input logic                value_ready,
    input logic                flags_ready,
    input logic [2*DATA_W-1:0] fwd_data,
    input logic                flag_n,
    input logic                flag_z
);

    p_stall_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ex_busy);

    p_stall_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ex_busy);

    p_mem_from_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> $past(ex_busy));

    p_wb_after_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |=> wb_valid);

    p_value_staged_r5: assert property (@(posedge clk) disable iff (!rst_n)
        value_ready |-> (ex_busy || mem_valid || wb_valid));

    p_flags_follow_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flags_ready |-> $past(value_ready));

    p_flags_in_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_ready |-> mem_valid);

    p_flags_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_ready |-> (!flag_n && !flag_z));

    p_lo_leads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (value_ready && !lo_ready) |-> $past(lo_ready));

    p_data_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(value_ready || lo_ready) |-> (fwd_data == '0));

endmodule

bind mulseq_top mulseq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall       (stall),
    .ex_busy     (ex_busy),
    .mem_valid   (mem_valid),
    .wb_valid    (wb_valid),
    .lo_ready    (lo_ready),
    .value_ready (value_ready),
    .flags_ready (flags_ready),
    .fwd_data    (fwd_data),
    .flag_n      (flag_n),
    .flag_z      (flag_z)
);

// File: tb/mulseq_top_tb_top.sv
`timescale 1ns/1ps
module mulseq_top_tb_top;

    localparam int W  = 32;
    localparam int NC = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [2:0]    issue_class = '0;
    logic [W-1:0]  op_a = '0, op_b = '0, op_acc = '0;
    logic          stall, ex_busy, mem_valid, wb_valid;
    logic          lo_ready, value_ready, flags_ready, flag_n, flag_z;
    logic [2*W-1:0] fwd_data;

    always #4 clk = ~clk;

    mulseq_top #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_class(issue_class), .op_a(op_a), .op_b(op_b), .op_acc(op_acc),
        .stall(stall), .ex_busy(ex_busy), .mem_valid(mem_valid),
        .wb_valid(wb_valid), .lo_ready(lo_ready), .value_ready(value_ready),
        .flags_ready(flags_ready), .fwd_data(fwd_data),
        .flag_n(flag_n), .flag_z(flag_z)
    );

    typedef struct {
        int          cls;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] acc;
        int          gap;
    } op_t;

    op_t ops[$];

    // expected trace, one entry per cycle
    bit        x_busy[NC], x_stall[NC], x_mem[NC], x_wb[NC];
    bit        x_lo[NC], x_val[NC], x_flg[NC], x_n[NC], x_z[NC];
    bit [63:0] x_dat[NC];

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int last_evt = 0;
    int gap_left = 0;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    function automatic int passes_of(int c);
        case (c)
            1, 2:    return 2;
            3:       return 4;
            4:       return 3;
            5:       return 5;
            default: return 1;
        endcase
    endfunction

    function automatic bit [63:0] ref_result(int c, logic [31:0] a, logic [31:0] b,
                                             logic [31:0] acc);
        shortint         sa = a[15:0];
        shortint         sb = b[15:0];
        int              hp = int'(sa) * int'(sb);
        logic [31:0]     hm = hp + acc;
        longint unsigned fp = {32'b0, a} * {32'b0, b};
        case (c)
            1:       return {32'b0, hm};
            2, 3:    return {32'b0, fp[31:0]};
            4, 5:    return fp;
            default: return {32'b0, hp};
        endcase
    endfunction

    task automatic add_op(int c, logic [31:0] a, logic [31:0] b, logic [31:0] acc, int gap);
        op_t o;
        o.cls = c; o.a = a; o.b = b; o.acc = acc; o.gap = gap;
        ops.push_back(o);
    endtask

    // k is the cycle of the first execute pass
    task automatic plan_op(int k, op_t o);
        int        p    = passes_of(o.cls);
        int        last = k + p - 1;
        int        vc;
        int        lc;
        bit [63:0] r    = ref_result(o.cls, o.a, o.b, o.acc);
        for (int j = k; j <= last; j++) begin
            x_busy[j] = 1'b1;
            if (j < last) x_stall[j] = 1'b1;
        end
        x_mem[last+1] = 1'b1;
        x_wb[last+2]  = 1'b1;
        if (o.cls == 1)                    vc = last + 1;
        else if (o.cls == 3 || o.cls == 5) vc = last;
        else                               vc = last + 2;
        if (o.cls == 4)      lc = last + 1;
        else if (o.cls == 5) lc = last - 1;
        else                 lc = vc;
        x_val[vc] = 1'b1; x_dat[vc] = r;
        x_lo[lc]  = 1'b1; x_dat[lc] = r;
        if (o.cls == 3 || o.cls == 5) begin
            x_flg[last+1] = 1'b1;
            x_n[last+1]   = (o.cls == 3) ? r[31] : r[63];
            x_z[last+1]   = (o.cls == 3) ? (r[31:0] == 32'b0) : (r == 64'b0);
        end
        if (last + 2 > last_evt) last_evt = last + 2;
    endtask

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic compare(int n);
        chk("R2",    "stall",       64'(stall),       64'(x_stall[n]));
        chk("R3",    "ex_busy",     64'(ex_busy),     64'(x_busy[n]));
        chk("R4",    "mem_valid",   64'(mem_valid),   64'(x_mem[n]));
        chk("R4",    "wb_valid",    64'(wb_valid),    64'(x_wb[n]));
        chk("R5/R6", "value_ready", 64'(value_ready), 64'(x_val[n]));
        chk("R8",    "lo_ready",    64'(lo_ready),    64'(x_lo[n]));
        chk("R7",    "flags_ready", 64'(flags_ready), 64'(x_flg[n]));
        chk("R7",    "flag_n",      64'(flag_n),      64'(x_n[n]));
        chk("R7",    "flag_z",      64'(flag_z),      64'(x_z[n]));
        chk("R9",    "fwd_data",    fwd_data,         x_dat[n]);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual hang expected completion");
        finish_run();
    end

    initial begin
        // R10: every class issued back to back, ascending then descending
        for (int c = 0; c < 8; c++)
            add_op(c, 32'h0001_2345 + 32'(c), 32'h0000_0107 + 32'(c * 3), 32'h0000_0100, 0);
        for (int c = 7; c >= 0; c--)
            add_op(c, 32'hFFFF_8001, 32'h0003_7FFF, 32'h1000_0000, 0);
        // R7 flag corner cases
        add_op(3, 32'h0000_0000, 32'h0000_0005, 32'h0, 0);
        add_op(3, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 0);
        add_op(5, 32'h0000_0000, 32'h0000_0009, 32'h0, 0);
        add_op(5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 0);
        add_op(3, 32'h0000_0003, 32'h0000_0007, 32'h0, 0);
        // idle gaps between operations
        for (int c = 0; c < 8; c++)
            add_op(c, 32'h8000_0003 ^ 32'(c << 20), 32'h7FFF_FFF1, 32'hFFFF_FFFF, 1 + (c % 2));
        // R10 dense mixes: wide then narrow, then accumulate after short
        add_op(4, 32'hDEAD_BEEF, 32'h1234_5678, 32'h0, 0);
        add_op(0, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0, 0);
        add_op(1, 32'h0000_7FFF, 32'h0000_8000, 32'h0000_0001, 0);
        add_op(5, 32'h0001_0000, 32'h0001_0000, 32'h0, 0);
        add_op(1, 32'h0000_0002, 32'h0000_0003, 32'hFFFF_FFFA, 0);
        add_op(2, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0, 0);

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet while reset is held
        chk("R1", "stall",       64'(stall),       64'd0);
        chk("R1", "ex_busy",     64'(ex_busy),     64'd0);
        chk("R1", "mem_valid",   64'(mem_valid),   64'd0);
        chk("R1", "wb_valid",    64'(wb_valid),    64'd0);
        chk("R1", "strobes",     64'({lo_ready, value_ready, flags_ready}), 64'd0);
        chk("R1", "flags",       64'({flag_n, flag_z}), 64'd0);
        chk("R1", "fwd_data",    fwd_data,         64'd0);
        rst_n = 1'b1;
        gap_left = ops[0].gap;

        while (1) begin
            compare(cyc);
            if (ops.size() > 0) begin
                if (gap_left > 0) begin
                    issue_valid = 1'b0;
                    gap_left--;
                end else begin
                    // R2: op held with issue_valid high while stalled
                    issue_valid = 1'b1;
                    issue_class = 3'(ops[0].cls);
                    op_a        = ops[0].a;
                    op_b        = ops[0].b;
                    op_acc      = ops[0].acc;
                    if (!x_stall[cyc]) begin
                        plan_op(cyc + 1, ops[0]);
                        ops.delete(0);
                        if (ops.size() > 0) gap_left = ops[0].gap;
                    end
                end
            end else begin
                issue_valid = 1'b0;
            end
            if (ops.size() == 0 && cyc > last_evt + 1) break;
            if (cyc >= NC - 8) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: cycle %0d actual still running expected done", cyc);
                break;
            end
            @(negedge clk);
        end
        finish_run();
    end

endmodule